// File: doc/BRIEF.md
# Double-Pumped RGB Pixel Reassembler

This block sits behind a 12-bit video bus that moves each 24-bit RGB pixel as two words on a clock running at twice the pixel rate. The first word of a pair holds all of red and the upper half of green. The second holds the lower half of green and all of blue. The block decides which beat is which, joins the two halves into one 8:8:8 pixel, and presents it with a one-cycle valid strobe. Each pixel carries the horizontal and vertical sync levels that arrived with its first word, and a data-enable taken from its own raster counters.

The beat phase is a one-bit toggle that starts on the first-word phase when reset is released. Whenever horizontal sync turns active, the toggle is forced back to the first-word phase, so a slipped or glitched bus is corrected one line later. Pixel and line counters restart from the sync edges. They mark the active area of a 720x480 progressive raster. A parameter can narrow the enable to a 640-pixel content window inside that area.

Top module: `pxj_top`

## Requirements
- R1: While reset is asserted, and until the first pixel leaves, the valid strobe, the RGB output and the data-enable are 0, and both sync outputs sit at their inactive level (high, for the default active-low syncs).
- R2: A pixel is rebuilt as red = first[11:4], green = {first[3:0], second[11:8]}, blue = second[7:0], and is driven on the RGB output as {red, green, blue}, with red in bits 23:16 and blue in bits 7:0.
- R3: The valid strobe is high for exactly the one cycle that follows the clock edge that captured a second word. It is never high in two consecutive cycles, and the data-enable is 0 whenever the valid strobe is 0.
- R4: The first beat sampled after reset is treated as a first word, and the phase alternates on every beat after that.
- R5: A beat on which horizontal sync is active, after it was inactive on the previous beat, is always taken as a first word. Any first word still waiting for its partner is dropped without producing a pixel, so pairing is correct again from that sync onward.
- R6: The sync outputs that come with a pixel equal the raw sync input levels sampled together with that pixel's first word.
- R7: The pixel whose sync sample shows horizontal sync turning active has horizontal index 0. The data-enable is high only for indices H_START to H_START+H_ACT-1.
- R8: The line on which vertical sync first turns active, counted from its first horizontal sync edge, has line index 0. The data-enable is high only on lines V_START to V_START+V_ACT-1.
- R9: With CONTENT_ONLY set, the horizontal part of the enable covers only the indices H_START+CONTENT_OFF to H_START+CONTENT_OFF+CONTENT_W-1.
- R10: After reset, and before the first horizontal and vertical sync edges, the data-enable stays 0 for every pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video clock, two beats per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_i | input | 12 | Double-pumped pixel word bus |
| hs_i | input | 1 | Horizontal sync input, polarity set by SYNC_LOW |
| vs_i | input | 1 | Vertical sync input, polarity set by SYNC_LOW |
| rgb_o | output | 24 | Rebuilt pixel {R, G, B} |
| pix_vld_o | output | 1 | One-cycle strobe, one per pixel |
| hs_o | output | 1 | Horizontal sync level aligned to the pixel |
| vs_o | output | 1 | Vertical sync level aligned to the pixel |
| de_o | output | 1 | Data-enable for the pixel being presented |

## Verification
A pixel's outputs are registered on the edge that samples its second word. They are therefore visible during the cycle after that edge, two edges after the first word was taken. The bench drives both words on falling edges. It checks the previous pixel's RGB, syncs and enables on the falling edge where it drives the next first word. On the falling edge in between, it checks that the strobe and enable have dropped. After a deliberately inserted stray beat, the bench stops checking until the next horizontal sync. It then expects the sync pixel's own beat to produce no output and the pixel after it to come out intact.

// File: rtl/pxj_pkg.sv
package pxj_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // Rejoin the two beat words; green is split across the pair.
  function automatic rgb_t join_words(input logic [11:0] hi, input logic [11:0] lo);
    rgb_t p;
    p.r = hi[11:4];
    p.g = {hi[3:0], lo[11:8]};
    p.b = lo[7:0];
    return p;
  endfunction

  // True when v lies in [base, base+len).
  function automatic logic in_span(input int unsigned v, input int unsigned base,
                                   input int unsigned len);
    return (v >= base) && (v < base + len);
  endfunction

endpackage

// File: rtl/pxj_beat_phase.sv
module pxj_beat_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_act,
  output logic msb_beat,
  output logic lsb_beat,
  output logic hs_lead
);
  logic hs_seen;
  logic odd;

  assign hs_lead  = hs_act & ~hs_seen;
  assign msb_beat = hs_lead | ~odd;
  assign lsb_beat = ~msb_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_seen <= 1'b0;
      odd     <= 1'b0;
    end else begin
      hs_seen <= hs_act;
      odd     <= msb_beat;
    end
  end
endmodule

// File: rtl/pxj_pair.sv
module pxj_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] vid,
  input  logic        hs_act,
  input  logic        vs_act,
  input  logic        msb_beat,
  output logic [11:0] hi_q,
  output logic        hs_q,
  output logic        vs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else if (msb_beat) begin
      hi_q <= vid;
      hs_q <= hs_act;
      vs_q <= vs_act;
    end
  end
endmodule

// File: rtl/pxj_raster.sv
module pxj_raster import pxj_pkg::*; #(
  parameter int H_TOTAL      = 858,
  parameter int H_START      = 122,
  parameter int H_ACT        = 720,
  parameter int V_TOTAL      = 525,
  parameter int V_START      = 36,
  parameter int V_ACT        = 480,
  parameter bit CONTENT_ONLY = 1'b0,
  parameter int CONTENT_OFF  = 40,
  parameter int CONTENT_W    = 640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic hs_a,
  input  logic vs_a,
  output logic de_now
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic [HW-1:0] h_reg, h_cur;
  logic [VW-1:0] v_reg, v_cur;
  logic hprev, vprev, vpend, vpend_nx;
  logic hl, vl, h_in, v_in;

  assign hl = hs_a & ~hprev;
  assign vl = vs_a & ~vprev;

  always_comb begin
    h_cur    = hl ? '0 : ((h_reg == H_LAST) ? h_reg : h_reg + 1'b1);
    v_cur    = v_reg;
    vpend_nx = vpend | vl;
    if (hl) begin
      v_cur    = (vpend | vl) ? '0 : ((v_reg == V_LAST) ? v_reg : v_reg + 1'b1);
      vpend_nx = 1'b0;
    end
  end

  generate
    if (CONTENT_ONLY) begin : g_content
      assign h_in = in_span(32'(h_cur), H_START + CONTENT_OFF, CONTENT_W);
    end else begin : g_full
      assign h_in = in_span(32'(h_cur), H_START, H_ACT);
    end
  endgenerate

  assign v_in   = in_span(32'(v_cur), V_START, V_ACT);
  assign de_now = h_in & v_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_reg <= H_LAST;
      v_reg <= V_LAST;
      hprev <= 1'b0;
      vprev <= 1'b0;
      vpend <= 1'b0;
    end else if (stb) begin
      h_reg <= h_cur;
      v_reg <= v_cur;
      hprev <= hs_a;
      vprev <= vs_a;
      vpend <= vpend_nx;
    end
  end
endmodule

// File: rtl/pxj_top.sv
module pxj_top import pxj_pkg::*; #(
  parameter bit SYNC_LOW     = 1'b1,
  parameter int H_TOTAL      = 858,
  parameter int H_START      = 122,
  parameter int H_ACT        = 720,
  parameter int V_TOTAL      = 525,
  parameter int V_START      = 36,
  parameter int V_ACT        = 480,
  parameter bit CONTENT_ONLY = 1'b0,
  parameter int CONTENT_OFF  = 40,
  parameter int CONTENT_W    = 640
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] vid_i,
  input  logic        hs_i,
  input  logic        vs_i,
  output logic [23:0] rgb_o,
  output logic        pix_vld_o,
  output logic        hs_o,
  output logic        vs_o,
  output logic        de_o
);
  logic hs_act, vs_act;
  logic msb_beat, lsb_beat, hs_lead;
  logic [11:0] hi_q;
  logic hs_q, vs_q, de_now;
  rgb_t joined;

  generate
    if (SYNC_LOW) begin : g_sync_low
      assign hs_act = ~hs_i;
      assign vs_act = ~vs_i;
    end else begin : g_sync_high
      assign hs_act = hs_i;
      assign vs_act = vs_i;
    end
  endgenerate

  pxj_beat_phase u_phase (
    .clk(clk), .rst_n(rst_n), .hs_act(hs_act),
    .msb_beat(msb_beat), .lsb_beat(lsb_beat), .hs_lead(hs_lead)
  );

  pxj_pair u_pair (
    .clk(clk), .rst_n(rst_n), .vid(vid_i), .hs_act(hs_act), .vs_act(vs_act),
    .msb_beat(msb_beat), .hi_q(hi_q), .hs_q(hs_q), .vs_q(vs_q)
  );

  pxj_raster #(
    .H_TOTAL(H_TOTAL), .H_START(H_START), .H_ACT(H_ACT),
    .V_TOTAL(V_TOTAL), .V_START(V_START), .V_ACT(V_ACT),
    .CONTENT_ONLY(CONTENT_ONLY), .CONTENT_OFF(CONTENT_OFF), .CONTENT_W(CONTENT_W)
  ) u_raster (
    .clk(clk), .rst_n(rst_n), .stb(lsb_beat), .hs_a(hs_q), .vs_a(vs_q), .de_now(de_now)
  );

  assign joined = join_words(hi_q, vid_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_o     <= '0;
      pix_vld_o <= 1'b0;
      hs_o      <= SYNC_LOW;
      vs_o      <= SYNC_LOW;
      de_o      <= 1'b0;
    end else begin
      pix_vld_o <= lsb_beat;
      de_o      <= lsb_beat & de_now;
      if (lsb_beat) begin
        rgb_o <= joined;
        hs_o  <= hs_q ^ SYNC_LOW;
        vs_o  <= vs_q ^ SYNC_LOW;
      end
    end
  end
endmodule

// File: rtl/pxj_chk.sv
module pxj_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] vid_i,
  input logic        hs_i,
  input logic        vs_i,
  input logic [23:0] rgb_o,
  input logic        pix_vld_o,
  input logic        hs_o,
  input logic        vs_o,
  input logic        de_o,
  input logic        hs_lead
);
  // R3: strobe is a single-cycle pulse
  p_strobe_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o |=> !pix_vld_o);

  // R3: enable only with a pixel
  p_de_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> pix_vld_o);

  // R2: green rejoined from the two most recent beats
  p_green_join_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o |-> rgb_o[15:8] == {$past(vid_i[3:0], 2), $past(vid_i[11:8], 1)});

  // R5: sync leading beat is a first word, so no pixel follows it
  p_lead_first_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lead |=> !pix_vld_o);

  // R6: syncs taken with the first word
  p_sync_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o |-> (hs_o == $past(hs_i, 2)) && (vs_o == $past(vs_i, 2)));
endmodule

bind pxj_top pxj_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vid_i(vid_i), .hs_i(hs_i), .vs_i(vs_i),
  .rgb_o(rgb_o), .pix_vld_o(pix_vld_o), .hs_o(hs_o), .vs_o(vs_o),
  .de_o(de_o), .hs_lead(hs_lead)
);

// File: tb/sim_pxj_top.sv
module sim_pxj_top;
  localparam int HT = 16, HS0 = 3, HA = 8, VT = 8, VS0 = 2, VA = 3, COFF = 2, CW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [11:0] vd;
  logic        hs, vs;
  logic [23:0] rgb, rgb1;
  logic        pv, hso, vso, de, pv1, hso1, vso1, de1;

  pxj_top #(.H_TOTAL(HT), .H_START(HS0), .H_ACT(HA), .V_TOTAL(VT), .V_START(VS0),
            .V_ACT(VA), .CONTENT_ONLY(1'b0), .CONTENT_OFF(COFF), .CONTENT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .vid_i(vd), .hs_i(hs), .vs_i(vs),
    .rgb_o(rgb), .pix_vld_o(pv), .hs_o(hso), .vs_o(vso), .de_o(de));

  pxj_top #(.H_TOTAL(HT), .H_START(HS0), .H_ACT(HA), .V_TOTAL(VT), .V_START(VS0),
            .V_ACT(VA), .CONTENT_ONLY(1'b1), .CONTENT_OFF(COFF), .CONTENT_W(CW)) u1 (
    .clk(clk), .rst_n(rst_n), .vid_i(vd), .hs_i(hs), .vs_i(vs),
    .rgb_o(rgb1), .pix_vld_o(pv1), .hs_o(hso1), .vs_o(vso1), .de_o(de1));

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  bit exp_pend = 1'b0, slipped = 1'b0;
  logic [23:0] e_rgb;
  logic e_hs, e_vs, e_de, e_de1;
  string rgb_tag = "R2", de_tag = "R7 R8";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference pixel: red, green, blue built separately, then packed.
  function automatic logic [23:0] pat(input int x, input int y, input int f);
    logic [7:0] r, g, b;
    r = 8'(x * 13 + y * 7 + f * 31);
    g = 8'((x * 5) ^ (y * 11) ^ 165 ^ f);
    b = 8'(255 - (x * 3 + y) + f * 9);
    return {r, g, b};
  endfunction

  task automatic check_pending();
    if (exp_pend) begin
      chk(pv == 1'b1, "R3", "valid", 32'(pv), 1);
      chk(rgb == e_rgb, rgb_tag, "rgb", 32'(rgb), 32'(e_rgb));
      chk({hso, vso} == {e_hs, e_vs}, "R6", "syncs", 32'({hso, vso}), 32'({e_hs, e_vs}));
      chk(de == e_de, de_tag, "de", 32'(de), 32'(e_de));
      chk(de1 == e_de1, "R9", "content de", 32'(de1), 32'(e_de1));
    end
    exp_pend = 1'b0;
  endtask

  task automatic send_px(input logic [23:0] p, input bit hsa, input bit vsa,
                         input bit de_e, input bit de1_e);
    @(negedge clk);
    check_pending();
    vd = {p[23:16], p[15:12]};
    hs = ~hsa;
    vs = ~vsa;
    @(negedge clk);
    if (!slipped) chk(pv == 1'b0 && de == 1'b0, "R3", "mid-pair idle", 32'({pv, de}), 0);
    vd = {p[11:8], p[7:0]};
    if (!slipped) begin
      exp_pend = 1'b1;
      e_rgb = p; e_hs = ~hsa; e_vs = ~vsa; e_de = de_e; e_de1 = de1_e;
    end
  endtask

  task automatic stray_beat();
    @(negedge clk);
    check_pending();
    vd = 12'h5A5;
    hs = 1'b1;
    slipped = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; vd = '0; hs = 1'b1; vs = 1'b1;
    repeat (3) @(negedge clk);
    chk(pv == 0 && rgb == 0 && de == 0 && de1 == 0, "R1", "outputs in reset",
        32'({pv, de, de1}), 0);
    chk(hso == 1 && vso == 1, "R1", "syncs in reset", 32'({hso, vso}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pv == 0 && rgb == 0 && hso == 1, "R1", "first cycle after reset",
        32'({pv, hso}), 1);
  endtask

  task automatic t_nosync();
    rgb_tag = "R4"; de_tag = "R10";
    for (int i = 0; i < 6; i++) send_px(pat(i, 9, 7), 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_frame(input int f, input int slip_line);
    rgb_tag = "R2"; de_tag = "R7 R8";
    for (int y = 0; y < VT; y++) begin
      for (int x = 0; x < HT; x++) begin
        bit vy;
        if (slipped && x == 0) begin
          slipped = 1'b0;
          rgb_tag = "R5";
        end
        vy = (y >= VS0) && (y < VS0 + VA);
        send_px(pat(x, y, f), x < 2, y == 0,
                vy && x >= HS0 && x < HS0 + HA,
                vy && x >= HS0 + COFF && x < HS0 + COFF + CW);
        if (y == slip_line && x == 12) stray_beat();
      end
    end
  endtask

  initial begin
    t_reset();
    t_nosync();
    t_frame(1, -1);
    t_frame(2, -1);
    t_frame(3, 3);
    t_frame(4, -1);
    @(negedge clk);
    check_pending();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule